// File: doc/BRIEF.md
# PWM Duty-Cycle Brightness Extractor

This block turns an external PWM brightness input into an 8-bit brightness code. The input is first brought into the system clock domain. The block then counts, on that fast clock, how many cycles the input spends high and how many cycles pass between two rising edges. A small sequential divider forms the ratio of the two as a 256-step code.

A code moves only when the change is big enough to be real. This keeps one-step jitter on the input from flickering the output. When the input stops toggling for longer than the slowest legal period, the code is forced to fully off or fully on, following the level the input is stuck at.

A mode input chooses how the measured duty is used. In direct mode the duty itself is the brightness. In percent mode the duty acts as a multiplier on a separately supplied 8-bit brightness value. Until a measurement exists, percent mode passes that value through unscaled.

Top module: `dcx_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `code_o` is 0 and `valid_o` is 0 (with `pct_mode_i` low).
- R2: For an input sampled high for H clock cycles in a period of P clock cycles (rising edge to rising edge), the measured duty code is floor(256*H/P), saturated to 255.
- R3: Each rising edge that closes a measured period yields exactly one result, marked by a `valid_o` pulse one clock cycle wide. The first rising edge after reset or after a timeout only arms the measurement and yields no result.
- R4: The held duty takes a new measurement only if it differs from the held value by 2 or more. A difference of exactly 1 keeps the held value. The first measurement is always taken.
- R5: With `pct_mode_i` high, `code_o` = floor(`reg_bright_i` * (duty + 1) / 256), where duty is the held duty code. `code_o` therefore never exceeds `reg_bright_i`.
- R6: Before any measurement or timeout exists, `code_o` is `reg_bright_i` in percent mode (duty taken as 255) and 0 in direct mode.
- R7: If no input edge occurs for IDLE_LIMIT cycles while the input is low, the held duty becomes 0 and `valid_o` pulses once.
- R8: If no input edge occurs for IDLE_LIMIT cycles while the input is high, the held duty becomes 255 and `valid_o` pulses once.

Output timing: `code_o` follows a change of `pct_mode_i` or `reg_bright_i` one cycle later. A new held duty appears on `code_o` in the same cycle as its `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | Asynchronous PWM brightness input |
| pct_mode_i | input | 1 | 1: duty scales `reg_bright_i`; 0: duty is the brightness |
| reg_bright_i | input | 8 | Brightness value scaled in percent mode |
| code_o | output | 8 | Brightness code |
| valid_o | output | 1 | One-cycle pulse on each measurement or timeout result |

## Verification
The bound checker watches, on every cycle:
- that `valid_o` is one cycle wide and low right after reset;
- that `code_o` moves only with a result pulse or a prior change of the mode or brightness inputs;
- that a direct-mode update never moves the code by exactly one step;
- that the percent-mode output never exceeds the supplied brightness.

Only the bench scenarios can show:
- that the divided value is correct for given high and low times;
- that a deliberate one-step alternation of the input is absorbed;
- that the stuck-low and stuck-high timeouts force the right levels;
- that measurement re-arms on the second rising edge after a timeout.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_FULL = '1;
    localparam logic [CODE_W-1:0] CODE_OFF  = '0;

    typedef enum logic {
        DIV_IDLE,
        DIV_RUN
    } div_state_e;

    typedef struct packed {
        logic              fire;
        logic              have;
        logic [CODE_W-1:0] duty;
    } duty_upd_t;

    // Percent scaling: brightness * (duty + 1) / 256
    function automatic logic [CODE_W-1:0] scale_bright(
        input logic [CODE_W-1:0] bright,
        input logic [CODE_W-1:0] duty
    );
        logic [2*CODE_W:0] prod;
        prod = {{(CODE_W+1){1'b0}}, bright} * {{CODE_W{1'b0}}, {1'b0, duty} + {{CODE_W{1'b0}}, 1'b1}};
        return prod[2*CODE_W-1:CODE_W];
    endfunction

    // True when codes are two or more steps apart
    function automatic logic far_apart(
        input logic [CODE_W-1:0] a,
        input logic [CODE_W-1:0] b
    );
        logic [CODE_W-1:0] d;
        d = (a > b) ? (a - b) : (b - a);
        return d > {{(CODE_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/dcx_edge_sync.sv
module dcx_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [2:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[1:0], async_i};
    end

    assign level_o = stage_q[1];
    assign rise_o  = stage_q[1] & ~stage_q[2];
    assign fall_o  = ~stage_q[1] & stage_q[2];
endmodule

// File: rtl/dcx_period_meter.sv
module dcx_period_meter #(
    parameter int CNT_W      = 19,
    parameter int IDLE_LIMIT = 300000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             meas_stb_o,
    output logic [CNT_W-1:0] meas_high_o,
    output logic [CNT_W-1:0] meas_period_o,
    output logic             stuck_stb_o,
    output logic             stuck_level_o
);
    localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0]  CNT_TOP   = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [IDLE_W-1:0] IDLE_END  = IDLE_W'(IDLE_LIMIT);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);

    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  high_q;
    logic [IDLE_W-1:0] idle_q;
    logic              armed_q;
    logic              any_edge;
    logic              idle_expire;

    assign any_edge    = rise_i | fall_i;
    assign idle_expire = !any_edge && (idle_q == IDLE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q      <= '0;
            high_q        <= '0;
            idle_q        <= '0;
            armed_q       <= 1'b0;
            meas_stb_o    <= 1'b0;
            meas_high_o   <= '0;
            meas_period_o <= '0;
            stuck_stb_o   <= 1'b0;
            stuck_level_o <= 1'b0;
        end else begin
            meas_stb_o  <= 1'b0;
            stuck_stb_o <= 1'b0;

            if (rise_i) begin
                if (armed_q && period_q != CNT_TOP) begin
                    meas_stb_o    <= 1'b1;
                    meas_high_o   <= high_q;
                    meas_period_o <= period_q;
                end
                armed_q  <= 1'b1;
                period_q <= CNT_ONE;
                high_q   <= CNT_ONE;
            end else begin
                if (period_q != CNT_TOP)
                    period_q <= period_q + CNT_ONE;
                if (level_i && high_q != CNT_TOP)
                    high_q <= high_q + CNT_ONE;
            end

            if (any_edge)
                idle_q <= '0;
            else if (idle_q != IDLE_END)
                idle_q <= idle_q + {{(IDLE_W-1){1'b0}}, 1'b1};

            if (idle_expire) begin
                stuck_stb_o   <= 1'b1;
                stuck_level_o <= level_i;
                armed_q       <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dcx_frac_div.sv
module dcx_frac_div
    import dcx_pkg::*;
#(
    parameter int NUM_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NUM_W-1:0]  high_i,
    input  logic [NUM_W-1:0]  period_i,
    output logic              done_o,
    output logic [CODE_W-1:0] quot_o
);
    localparam int STEP_W = $clog2(CODE_W + 1);
    localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

    div_state_e        state_q;
    logic [NUM_W:0]    rem_q;
    logic [NUM_W-1:0]  den_q;
    logic [CODE_W-1:0] quot_q;
    logic [STEP_W-1:0] step_q;
    logic              sat_q;
    logic [NUM_W:0]    trial;
    logic              take;

    always_comb begin
        trial = {rem_q[NUM_W-1:0], 1'b0};
        take  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            rem_q   <= '0;
            den_q   <= '0;
            quot_q  <= '0;
            step_q  <= '0;
            sat_q   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                state_q <= DIV_RUN;
                rem_q   <= {1'b0, high_i};
                den_q   <= period_i;
                quot_q  <= '0;
                step_q  <= STEP_W'(CODE_W);
                sat_q   <= high_i >= period_i;
            end else if (state_q == DIV_RUN) begin
                rem_q  <= take ? (trial - {1'b0, den_q}) : trial;
                quot_q <= {quot_q[CODE_W-2:0], take};
                step_q <= step_q - STEP_ONE;
                if (step_q == STEP_ONE) begin
                    state_q <= DIV_IDLE;
                    done_o  <= 1'b1;
                end
            end
        end
    end

    assign quot_o = sat_q ? CODE_FULL : quot_q;
endmodule

// File: rtl/dcx_top.sv
module dcx_top
    import dcx_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int IDLE_LIMIT = 300000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwm_i,
    input  logic        pct_mode_i,
    input  logic [7:0]  reg_bright_i,
    output logic [7:0]  code_o,
    output logic        valid_o
);
    logic             lvl, rise, fall;
    logic             meas_stb;
    logic [CNT_W-1:0] meas_high, meas_period;
    logic             stuck_stb, stuck_lvl;
    logic             div_done;
    logic [CODE_W-1:0] div_quot;

    logic [CODE_W-1:0] held_q;
    logic              have_q;
    duty_upd_t         upd;
    logic [CODE_W-1:0] out_n;

    dcx_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pwm_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    dcx_period_meter #(
        .CNT_W      (CNT_W),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_meter (
        .clk           (clk),
        .rst           (rst),
        .level_i       (lvl),
        .rise_i        (rise),
        .fall_i        (fall),
        .meas_stb_o    (meas_stb),
        .meas_high_o   (meas_high),
        .meas_period_o (meas_period),
        .stuck_stb_o   (stuck_stb),
        .stuck_level_o (stuck_lvl)
    );

    dcx_frac_div #(
        .NUM_W (CNT_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start_i  (meas_stb),
        .high_i   (meas_high),
        .period_i (meas_period),
        .done_o   (div_done),
        .quot_o   (div_quot)
    );

    always_comb begin
        upd.fire = 1'b0;
        upd.have = have_q;
        upd.duty = held_q;
        if (stuck_stb) begin
            upd.fire = 1'b1;
            upd.have = 1'b1;
            upd.duty = stuck_lvl ? CODE_FULL : CODE_OFF;
        end else if (div_done) begin
            upd.fire = 1'b1;
            upd.have = 1'b1;
            if (!have_q || far_apart(div_quot, held_q))
                upd.duty = div_quot;
        end

        if (pct_mode_i)
            out_n = scale_bright(reg_bright_i, upd.have ? upd.duty : CODE_FULL);
        else
            out_n = upd.have ? upd.duty : CODE_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= CODE_OFF;
            have_q  <= 1'b0;
            code_o  <= CODE_OFF;
            valid_o <= 1'b0;
        end else begin
            held_q  <= upd.duty;
            have_q  <= upd.have;
            code_o  <= out_n;
            valid_o <= upd.fire;
        end
    end
endmodule

// File: rtl/dcx_checker.sv
module dcx_checker (
    input logic       clk,
    input logic       rst,
    input logic       pct_mode_i,
    input logic [7:0] reg_bright_i,
    input logic [7:0] code_o,
    input logic       valid_o,
    input logic       have_q,
    input logic       stuck_stb
);
    logic [1:0] age_q;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
    assign settled = (age_q == 2'd3);

    // R1
    valid_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid_o);

    // R3
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R3
    code_moves_only_on_result_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && !valid_o
         && $past(pct_mode_i) == $past(pct_mode_i, 2)
         && $past(reg_bright_i) == $past(reg_bright_i, 2)) |-> $stable(code_o));

    // R4
    no_single_step_update_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && valid_o && $past(have_q) && !$past(stuck_stb)
         && !$past(pct_mode_i) && !$past(pct_mode_i, 2))
        |-> ((8'(code_o - $past(code_o)) != 8'd1) && (8'(code_o - $past(code_o)) != 8'd255)));

    // R5
    pct_not_above_bright_chk: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(pct_mode_i)) |-> (code_o <= $past(reg_bright_i)));
endmodule

bind dcx_top dcx_checker u_dcx_checker (
    .clk          (clk),
    .rst          (rst),
    .pct_mode_i   (pct_mode_i),
    .reg_bright_i (reg_bright_i),
    .code_o       (code_o),
    .valid_o      (valid_o),
    .have_q       (have_q),
    .stuck_stb    (stuck_stb)
);

// File: tb/dcx_top_tb.sv
`timescale 1ns/1ps
module dcx_top_tb_top;
    localparam int IDLE = 3000;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [11:0] hi;
        logic [11:0] lo;
        logic        pct;
        logic [7:0]  bright;
        logic [7:0]  expect_code;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{12'd64,  12'd192, 1'b0, 8'd0,   8'd64},
        '{12'd100, 12'd100, 1'b0, 8'd0,   8'd128},
        '{12'd129, 12'd127, 1'b0, 8'd0,   8'd128},
        '{12'd130, 12'd126, 1'b0, 8'd0,   8'd130},
        '{12'd30,  12'd70,  1'b0, 8'd0,   8'd76},
        '{12'd1,   12'd99,  1'b0, 8'd0,   8'd2},
        '{12'd99,  12'd1,   1'b0, 8'd0,   8'd253},
        '{12'd50,  12'd50,  1'b1, 8'd200, 8'd100},
        '{12'd75,  12'd25,  1'b1, 8'd255, 8'd192},
        '{12'd10,  12'd90,  1'b1, 8'd100, 8'd10},
        '{12'd200, 12'd56,  1'b1, 8'd0,   8'd0},
        '{12'd255, 12'd1,   1'b0, 8'd0,   8'd255}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm = 1'b0;
    logic       pct = 1'b0;
    logic [7:0] bright = 8'd0;
    logic [7:0] code_o;
    logic       valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    int vcnt   = 0;
    int vbase;
    bit finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (valid_o) vcnt <= vcnt + 1;

    dcx_top #(.CNT_W(12), .IDLE_LIMIT(IDLE)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pwm_i        (pwm),
        .pct_mode_i   (pct),
        .reg_bright_i (bright),
        .code_o       (code_o),
        .valid_o      (valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_period(input int h, input int l);
        pwm = 1'b1;
        repeat (h) @(negedge clk);
        pwm = 1'b0;
        repeat (l) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 code in reset", code_o, 0);
        chk("R1 valid in reset", valid_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code after reset", code_o, 0);
        chk("R1 valid after reset", valid_o, 0);

        // R6: no measurement yet
        pct = 1'b1; bright = 8'd200;
        repeat (2) @(negedge clk);
        chk("R6 percent passthrough", code_o, 200);
        pct = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 direct zero", code_o, 0);

        // R2 R4 R5 R3: table walk
        for (int i = 0; i < NVEC; i++) begin
            pct = VECS[i].pct;
            bright = VECS[i].bright;
            vbase = vcnt;
            for (int p = 0; p < 4; p++) run_period(int'(VECS[i].hi), int'(VECS[i].lo));
            chk($sformatf("R2/R4/R5 vector %0d code", i), code_o, int'(VECS[i].expect_code));
            chk($sformatf("R3 vector %0d results", i), vcnt - vbase, (i == 0) ? 3 : 4);
        end
        pct = 1'b0;

        // R4: one-step jitter absorbed
        for (int p = 0; p < 3; p++) run_period(256, 256);
        chk("R4 jitter base", code_o, 128);
        vbase = vcnt;
        for (int p = 0; p < 6; p++) begin
            if (p % 2 == 0) run_period(255, 257);
            else            run_period(257, 255);
        end
        chk("R4 jitter held", code_o, 128);
        chk("R3 jitter results", vcnt - vbase, 6);

        // R7: stuck low
        vbase = vcnt;
        repeat (IDLE + 100) @(negedge clk);
        chk("R7 stuck low code", code_o, 0);
        chk("R7 stuck low pulses", vcnt - vbase, 1);

        // R8: stuck high
        vbase = vcnt;
        pwm = 1'b1;
        repeat (IDLE + 100) @(negedge clk);
        chk("R8 stuck high code", code_o, 255);
        chk("R8 stuck high pulses", vcnt - vbase, 1);
        pct = 1'b1; bright = 8'd77;
        repeat (2) @(negedge clk);
        chk("R5 R8 percent at full duty", code_o, 77);
        pct = 1'b0;

        // R3: re-arm after timeout
        pwm = 1'b0;
        repeat (50) @(negedge clk);
        vbase = vcnt;
        run_period(64, 192);
        chk("R3 first edge after timeout silent", vcnt - vbase, 0);
        run_period(64, 192);
        chk("R3 second edge result", vcnt - vbase, 1);
        chk("R2 rearmed code", code_o, 64);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule